// File: doc/BRIEF.md
# Sensor Readout Timing Generator

This block sequences the readout of a colour-filtered photodiode array, nominally 352 columns by 288 rows. It counts clocks within a line and lines within a frame. From those counts it derives active-low horizontal and vertical sync pulses, a high-true pixel strobe, the row and column address of the photosite being read, and the colour-filter phase of that photosite. Rows are read one after another. Each row is addressed only after the previous one has been fully output. While a row is active, one photosite is addressed per clock.

Three run-time settings shape the frame. A format code picks the output window:
- full resolution;
- a quarter window that strobes every other pixel of every other row;
- a double-width window that holds each column for two clocks.

A rate code picks one of eight frame periods, from the base rate down to one thirtieth of it. The line length stays fixed, and the slower rates are made by adding blanking lines. A row delay sets how many lines after the vertical sync leading edge the first active row appears. All three settings are sampled only on the final clock of a frame, so every frame is internally consistent.

The block has no data path and no handshake. Its outputs are free-running timing, and no back-pressure exists. A downstream consumer must accept a pixel on every clock in which the pixel strobe is high.

Top module: `sensor_timing_gen`

## Requirements
- R1: While reset is asserted, hs_n and vs_n are 1 and href, row_addr, col_addr and cphase are 0. The first frame after reset uses format 0, rate code 0 and row delay 0, whatever the configuration inputs hold.
- R2: A line lasts HS_W+HBP+2*COLS+HFP clocks, and hs_n is 0 for exactly the first HS_W clocks of each line.
- R3: vs_n is 0 for the first VS_W lines of each frame. Its falling edge coincides with the falling edge of hs_n.
- R4: Active rows begin cfg_row_dly lines after the vs_n falling edge and occupy ROWS consecutive lines. row_addr counts 0 to ROWS-1, one step per line. A requested delay above VBLANK is clamped to VBLANK.
- R5: Format code 0 (full) raises href for COLS consecutive clocks, starting at clock HS_W+HBP of each active line, with col_addr counting 0 to COLS-1, one step per clock.
- R6: Format code 1 (quarter) raises href only where both row_addr and col_addr are even. The addresses still step through the full array.
- R7: Format code 2 (double-width) raises href for 2*COLS consecutive clocks per active line, and col_addr advances every second clock.
- R8: During the active window cphase equals {row_addr[0], col_addr[0]}: 0 blue, 1 green on a blue row, 2 green on a red row, 3 red. Outside the window cphase, row_addr and col_addr are 0.
- R9: A frame lasts (ROWS+VBLANK)*N lines, where N is 1, 2, 3, 5, 6, 10, 15 or 30 for rate codes 0 to 7.
- R10: Format, rate and delay inputs are sampled only on the last clock of a frame. A change made mid-frame does not alter the frame in progress.
- R11: Format code 3 behaves exactly as format code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Output window select: 0 full, 1 quarter, 2 double-width, 3 full |
| cfg_rate | input | 3 | Frame period step, 0 fastest to 7 slowest |
| cfg_row_dly | input | DLYW | Lines from vertical sync leading edge to first active row |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync, active low |
| href | output | 1 | Pixel strobe, high for each output pixel |
| row_addr | output | clog2(ROWS) | Row of the photosite being read |
| col_addr | output | clog2(COLS) | Column of the photosite being read |
| cphase | output | 2 | Colour-filter phase of the addressed photosite |

## Verification
The case hardest to reach from the ports is a configuration change arriving in the middle of a frame. It must be held off until the frame wraps, and it must meet a row delay large enough to be clamped at the slowest rate. The stimulus changes the inputs halfway through every measured frame, so each frame's shape is checked while new values are pending. A reduced array size keeps the thirty-fold slowest frame within a few thousand clocks. The last vector combines rate code 7 with an out-of-range delay, so the clamp and the longest frame are exercised together.

// File: rtl/stg_pkg.sv
package stg_pkg;

  typedef enum logic [1:0] {
    FMT_FULL  = 2'd0,
    FMT_HALF  = 2'd1,
    FMT_WIDE  = 2'd2,
    FMT_SPARE = 2'd3
  } fmt_e;

  // number of base frame periods per output frame for each rate step
  function automatic int unsigned rate_div(input logic [2:0] code);
    case (code)
      3'd0: rate_div = 1;
      3'd1: rate_div = 2;
      3'd2: rate_div = 3;
      3'd3: rate_div = 5;
      3'd4: rate_div = 6;
      3'd5: rate_div = 10;
      3'd6: rate_div = 15;
      default: rate_div = 30;
    endcase
  endfunction

endpackage

// File: rtl/stg_hcount.sv
module stg_hcount #(
  parameter int LINE_CLKS = 768,
  parameter int HS_W      = 16,
  parameter int HW        = $clog2(LINE_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [HW-1:0] hcnt,
  output logic          line_end,
  output logic          hs_act
);

  localparam logic [HW-1:0] LAST_V = HW'(LINE_CLKS - 1);
  localparam logic [HW-1:0] HSW_V  = HW'(HS_W);

  assign line_end = (hcnt == LAST_V);
  assign hs_act   = (hcnt < HSW_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hcnt <= '0;
    else if (run) hcnt <= line_end ? '0 : hcnt + 1'b1;
  end

  // a new line always opens with the sync pulse
  assert_line_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && line_end) |=> (hs_act && !line_end));

endmodule

// File: rtl/stg_vcount.sv
module stg_vcount import stg_pkg::*; #(
  parameter int ROWS       = 288,
  parameter int BASE_LINES = 300,
  parameter int VS_W       = 4,
  parameter int DLYW       = 6,
  parameter int VW         = $clog2(BASE_LINES * 30 + 1),
  parameter int RW         = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            line_end,
  input  logic [1:0]      cfg_fmt,
  input  logic [2:0]      cfg_rate,
  input  logic [DLYW-1:0] cfg_row_dly,
  output fmt_e            fmt_q,
  output logic            vs_act,
  output logic            row_act,
  output logic [RW-1:0]   row_idx,
  output logic            frame_end
);

  localparam logic [VW-1:0] MAXD_V = VW'(BASE_LINES - ROWS);
  localparam logic [VW-1:0] ROWS_V = VW'(ROWS);
  localparam logic [VW-1:0] VSW_V  = VW'(VS_W);

  logic [VW-1:0] vcnt, dly_q, dly_in, frame_last;
  logic [2:0]    rate_q;

  assign frame_last = VW'(BASE_LINES * rate_div(rate_q) - 1);
  assign frame_end  = line_end && (vcnt == frame_last);
  assign dly_in     = VW'(cfg_row_dly);

  // settings move only on the frame boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q  <= FMT_FULL;
      rate_q <= 3'd0;
      dly_q  <= '0;
    end else if (run && frame_end) begin
      fmt_q  <= fmt_e'(cfg_fmt);
      rate_q <= cfg_rate;
      dly_q  <= (dly_in > MAXD_V) ? MAXD_V : dly_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                vcnt <= '0;
    else if (run && line_end)  vcnt <= frame_end ? '0 : vcnt + 1'b1;
  end

  assign vs_act  = (vcnt < VSW_V);
  assign row_act = (vcnt >= dly_q) && (vcnt < (dly_q + ROWS_V));
  assign row_idx = RW'(vcnt - dly_q);

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && frame_end) |=> ($stable(fmt_q) && $stable(rate_q) && $stable(dly_q)));

  assert_dly_clamped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && frame_end && (dly_in > MAXD_V)) |=> (dly_q == MAXD_V));

endmodule

// File: rtl/stg_strobe.sv
module stg_strobe import stg_pkg::*; #(
  parameter int COLS       = 352,
  parameter int HACT_START = 40,
  parameter int HW         = 10,
  parameter int RW         = 9,
  parameter int CW         = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] hcnt,
  input  fmt_e          fmt_q,
  input  logic          row_act,
  input  logic [RW-1:0] row_idx,
  output logic          href,
  output logic [RW-1:0] row_addr,
  output logic [CW-1:0] col_addr,
  output logic [1:0]    cphase
);

  localparam logic [HW-1:0] HST_V  = HW'(HACT_START);
  localparam logic [HW:0]   SPAN_N = (HW+1)'(COLS);
  localparam logic [HW:0]   SPAN_W = (HW+1)'(2 * COLS);

  logic [HW-1:0] hrel;
  logic [CW-1:0] col;
  logic          wide, half, in_col, win;

  assign wide   = (fmt_q == FMT_WIDE);
  assign half   = (fmt_q == FMT_HALF);
  assign hrel   = hcnt - HST_V;
  assign in_col = (hcnt >= HST_V) && ({1'b0, hrel} < (wide ? SPAN_W : SPAN_N));
  assign col    = wide ? CW'(hrel >> 1) : CW'(hrel);
  assign win    = run && row_act && in_col;

  assign href     = win && !(half && (row_idx[0] || col[0]));
  assign row_addr = win ? row_idx : '0;
  assign col_addr = win ? col : '0;
  assign cphase   = win ? {row_idx[0], col[0]} : 2'b00;

  assert_half_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (href && half) |-> (!row_addr[0] && !col_addr[0]));

  assert_col_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(href) && !half) |-> (col_addr == '0));

endmodule

// File: rtl/sensor_timing_gen.sv
module sensor_timing_gen import stg_pkg::*; #(
  parameter int COLS   = 352,
  parameter int ROWS   = 288,
  parameter int HS_W   = 16,
  parameter int HBP    = 24,
  parameter int HFP    = 24,
  parameter int VBLANK = 12,
  parameter int VS_W   = 4,
  parameter int DLYW   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cfg_fmt,
  input  logic [2:0]               cfg_rate,
  input  logic [DLYW-1:0]          cfg_row_dly,
  output logic                     hs_n,
  output logic                     vs_n,
  output logic                     href,
  output logic [$clog2(ROWS)-1:0]  row_addr,
  output logic [$clog2(COLS)-1:0]  col_addr,
  output logic [1:0]               cphase
);

  localparam int LINE_CLKS  = HS_W + HBP + 2 * COLS + HFP;
  localparam int BASE_LINES = ROWS + VBLANK;
  localparam int HACT_START = HS_W + HBP;
  localparam int HW         = $clog2(LINE_CLKS);
  localparam int VW         = $clog2(BASE_LINES * 30 + 1);
  localparam int RW         = $clog2(ROWS);
  localparam int CW         = $clog2(COLS);

  logic          run, line_end, hs_act, vs_act, row_act, frame_end;
  logic [HW-1:0] hcnt;
  logic [RW-1:0] row_idx;
  fmt_e          fmt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= 1'b1;
  end

  stg_hcount #(.LINE_CLKS(LINE_CLKS), .HS_W(HS_W), .HW(HW)) u_h (
    .clk(clk), .rst_n(rst_n), .run(run),
    .hcnt(hcnt), .line_end(line_end), .hs_act(hs_act)
  );

  stg_vcount #(.ROWS(ROWS), .BASE_LINES(BASE_LINES), .VS_W(VS_W),
               .DLYW(DLYW), .VW(VW), .RW(RW)) u_v (
    .clk(clk), .rst_n(rst_n), .run(run), .line_end(line_end),
    .cfg_fmt(cfg_fmt), .cfg_rate(cfg_rate), .cfg_row_dly(cfg_row_dly),
    .fmt_q(fmt_q), .vs_act(vs_act), .row_act(row_act),
    .row_idx(row_idx), .frame_end(frame_end)
  );

  stg_strobe #(.COLS(COLS), .HACT_START(HACT_START),
               .HW(HW), .RW(RW), .CW(CW)) u_s (
    .clk(clk), .rst_n(rst_n), .run(run), .hcnt(hcnt), .fmt_q(fmt_q),
    .row_act(row_act), .row_idx(row_idx), .href(href),
    .row_addr(row_addr), .col_addr(col_addr), .cphase(cphase)
  );

  assign hs_n = !(run && hs_act);
  assign vs_n = !(run && vs_act);

  assert_href_clear_of_hs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    href |-> hs_n);

  assert_vs_at_line_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vs_n) |-> $fell(hs_n));

  assert_row_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    href |-> ({1'b0, row_addr} < (RW+1)'(ROWS)));

endmodule

// File: tb/sim_sensor_timing_gen.sv
module sim_sensor_timing_gen;
  localparam int COLS = 8, ROWS = 6, HS_W = 2, HBP = 2, HFP = 2;
  localparam int VBLANK = 4, VS_W = 2, DLYW = 4;
  localparam int LINE = HS_W + HBP + 2 * COLS + HFP;
  localparam int BASE = ROWS + VBLANK;
  localparam int HST  = HS_W + HBP;
  localparam int MAXD = BASE - ROWS;
  localparam int RW = $clog2(ROWS), CW = $clog2(COLS);

  // {fmt[25:24], rate[23:21], dly[20:17], frame lines[16:8], href count[7:0]}
  localparam logic [25:0] VEC [8] = '{
    {2'd0, 3'd0, 4'd0,  9'd10,  8'd48},
    {2'd1, 3'd1, 4'd1,  9'd20,  8'd12},
    {2'd2, 3'd2, 4'd2,  9'd30,  8'd96},
    {2'd0, 3'd3, 4'd3,  9'd50,  8'd48},
    {2'd1, 3'd4, 4'd4,  9'd60,  8'd12},
    {2'd2, 3'd5, 4'd0,  9'd100, 8'd96},
    {2'd3, 3'd6, 4'd2,  9'd150, 8'd48},
    {2'd0, 3'd7, 4'd15, 9'd300, 8'd48}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n;
  logic [1:0]      cfg_fmt;
  logic [2:0]      cfg_rate;
  logic [DLYW-1:0] cfg_row_dly;
  logic            hs_n, vs_n, href;
  logic [RW-1:0]   row_addr;
  logic [CW-1:0]   col_addr;
  logic [1:0]      cphase;

  sensor_timing_gen #(.COLS(COLS), .ROWS(ROWS), .HS_W(HS_W), .HBP(HBP), .HFP(HFP),
                      .VBLANK(VBLANK), .VS_W(VS_W), .DLYW(DLYW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_rate(cfg_rate),
    .cfg_row_dly(cfg_row_dly), .hs_n(hs_n), .vs_n(vs_n), .href(href),
    .row_addr(row_addr), .col_addr(col_addr), .cphase(cphase)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int m_h, m_v, m_fmt, m_rate, m_dly;
  bit m_run;
  int a_href, a_lines;
  logic prev_hs = 1'b1;
  int mm [6];
  int f_act [6];
  int f_exp [6];

  function automatic int div_of(input int c);
    case (c)
      0: return 1;  1: return 2;  2: return 3;  3: return 5;
      4: return 6;  5: return 10; 6: return 15; default: return 30;
    endcase
  endfunction

  function automatic string fmt_tag(input int f);
    case (f)
      1: return "R6";
      2: return "R7";
      3: return "R11";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic note(input int idx, input int act, input int exp);
    if (act != exp) begin
      if (mm[idx] == 0) begin f_act[idx] = act; f_exp[idx] = exp; end
      mm[idx]++;
    end
  endtask

  task automatic step();
    int rr, cc, span;
    bit act, win, wide, half, e_href;
    @(negedge clk);
    if (!rst_n) begin
      m_run = 0; m_h = 0; m_v = 0; m_fmt = 0; m_rate = 0; m_dly = 0;
    end else if (!m_run) begin
      m_run = 1;
    end else if (m_h == LINE - 1) begin
      m_h = 0;
      if (m_v == BASE * div_of(m_rate) - 1) begin
        m_v = 0; m_fmt = int'(cfg_fmt); m_rate = int'(cfg_rate);
        m_dly = (int'(cfg_row_dly) > MAXD) ? MAXD : int'(cfg_row_dly);
      end else m_v++;
    end else m_h++;
    act  = m_run && rst_n;
    wide = (m_fmt == 2);
    half = (m_fmt == 1);
    span = wide ? 2 * COLS : COLS;
    rr   = m_v - m_dly;
    cc   = wide ? (m_h - HST) / 2 : m_h - HST;
    win  = act && m_v >= m_dly && m_v < m_dly + ROWS && m_h >= HST && m_h < HST + span;
    e_href = win && !(half && ((rr % 2) != 0 || (cc % 2) != 0));
    note(0, int'(hs_n), int'(!(act && m_h < HS_W)));
    note(1, int'(vs_n), int'(!(act && m_v < VS_W)));
    note(2, int'(href), int'(e_href));
    note(3, int'(row_addr), win ? rr : 0);
    note(4, int'(col_addr), win ? cc : 0);
    note(5, int'(cphase), win ? (rr % 2) * 2 + (cc % 2) : 0);
    a_href += int'(href);
    if (prev_hs && !hs_n) a_lines++;
    prev_hs = hs_n;
  endtask

  task automatic clear_acc();
    a_href = 0; a_lines = 0;
    for (int i = 0; i < 6; i++) begin mm[i] = 0; f_act[i] = 0; f_exp[i] = 0; end
  endtask

  // one frame starting at line 0 clock 0; next settings applied halfway through
  task automatic measure(input int exp_lines, input int exp_href, input logic [8:0] nxt,
                         input string ftag);
    string ft;
    ft = fmt_tag(m_fmt);
    clear_acc();
    do begin
      step();
      if (m_v == exp_lines / 2 && m_h == 0) begin
        cfg_fmt = nxt[8:7]; cfg_rate = nxt[6:4]; cfg_row_dly = nxt[3:0];
      end
    end while (!(m_h == 0 && m_v == 0));
    check("R2", $sformatf("hs_n mismatches (first %0d/%0d)", f_act[0], f_exp[0]), mm[0], 0);
    check("R3", $sformatf("vs_n mismatches (first %0d/%0d)", f_act[1], f_exp[1]), mm[1], 0);
    check(ft, $sformatf("href mismatches (first %0d/%0d)", f_act[2], f_exp[2]), mm[2], 0);
    check("R4", $sformatf("row_addr mismatches (first %0d/%0d)", f_act[3], f_exp[3]), mm[3], 0);
    check(ft, $sformatf("col_addr mismatches (first %0d/%0d)", f_act[4], f_exp[4]), mm[4], 0);
    check("R8", $sformatf("cphase mismatches (first %0d/%0d)", f_act[5], f_exp[5]), mm[5], 0);
    check(ftag, "lines per frame", a_lines, exp_lines);
    check(ft, "href strobes per frame", a_href, exp_href);
  endtask

  task automatic check_reset_outputs();
    check("R1", "hs_n in reset", int'(hs_n), 1);
    check("R1", "vs_n in reset", int'(vs_n), 1);
    check("R1", "href in reset", int'(href), 0);
    check("R1", "row_addr in reset", int'(row_addr), 0);
    check("R1", "col_addr in reset", int'(col_addr), 0);
    check("R1", "cphase in reset", int'(cphase), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_fmt = VEC[1][25:24]; cfg_rate = VEC[1][23:21]; cfg_row_dly = VEC[1][20:17];
    repeat (3) step();
    check_reset_outputs();
    rst_n = 1'b1;
    step();
    check("R2", "hs_n low on first clock of frame", int'(hs_n), 0);
    check("R3", "vs_n low on first clock of frame", int'(vs_n), 0);
    // first frame ignores the non-default inputs held through reset
    measure(10, 48, VEC[0][25:17], "R1");
    for (int k = 0; k < 8; k++) begin
      measure(int'(VEC[k][16:8]), int'(VEC[k][7:0]), VEC[(k + 1) % 8][25:17], "R9,R10");
    end
    // reset in mid-frame returns outputs to rest and the settings to defaults
    repeat (37) step();
    rst_n = 1'b0;
    step();
    check_reset_outputs();
    cfg_fmt = 2'd2; cfg_rate = 3'd1; cfg_row_dly = 4'd1;
    rst_n = 1'b1;
    step();
    measure(10, 48, {2'd1, 3'd0, 4'd0}, "R1");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule